// File: doc/BRIEF.md
# Transmit Header-Insertion Gearbox

This block turns a stream of 64-bit payload blocks, each carrying a 2-bit or 3-bit sync header, into an unbroken stream of fixed-width output words for a 64B/66B or 64B/67B line. The user side and the output side have the same word width, either 2 or 4 bytes, and share one clock. Each block carries extra header bits, so the output side needs fewer payload words than cycles. The block keeps its own running count of the surplus bits it is buffering. It tells the user when to hold back data by lowering `ready`.

After reset the block outputs an idle pattern and waits. The user can leave the first header and data word on the inputs for as long as needed. Transmission begins in the cycle in which `start_seq` is high while `ready` is high. From then on, one output word leaves every cycle.

The pause protocol works as follows. In the first cycle with `ready` low, the word on the inputs is still taken. The block then takes nothing for the time of four bytes. `ready` comes back high one cycle before taking resumes.

Top module: `gbx_tx`

## Requirements
- R1: While `rst` is high, `ready` is low and `tx_word` shows the idle pattern. `ready` goes high at the first clock edge at which `rst` is sampled low.
- R2: Until the sequence starts, `tx_word` holds the idle pattern, and `data_in` and `hdr_in` are ignored however long they are held. The default idle pattern is 2'b01 repeated, with bit 0 = 1.
- R3: The sequence starts in the cycle in which `start_seq` is high and `ready` is high. That cycle's `hdr_in` and `data_in` form the first word of the first block. At the next edge, `tx_word` equals the low W bits of {`data_in`, `hdr_in`}, with the header at bit 0.
- R4: The line bit stream is the header, with `hdr_in` bit 0 first, followed by the 64 payload bits, with `data_in` bit 0 of each word first. Output words are packed back to back with no gaps, and `tx_word` bit 0 is the earliest bit.
- R5: `hdr_in` is sampled only on the first of every 64/W taken words. It is ignored on the other words of the block.
- R6: In the first cycle in which `ready` is low, the word on `data_in` is still taken.
- R7: After that cycle, no word is taken for 32/W cycles. `ready` stays low for 32/W consecutive cycles, counting the taking cycle, and is high in the last cycle that takes nothing. Taking resumes in the following cycle.
- R8: A pause begins when the buffered surplus of header bits reaches 32. With a 2-bit header and a 4-byte width, the first `ready`-low cycle is cycle 30, counting the start cycle as cycle 0. Later ones follow every 33 cycles.
- R9: From the edge after the start cycle, one W-bit word leaves on `tx_word` every cycle, and no buffered bit is lost or repeated.
- R10: Once the sequence runs, `start_seq` has no effect.
- R11: A synchronous reset in the middle of a stream returns the block to the state of R1 and R2. A new `start_seq` is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by user side and output side |
| rst | input | 1 | Synchronous reset, active high |
| start_seq | input | 1 | Starts the sequence when high with ready high |
| hdr_in | input | HDR_W | Sync header of the block whose first word is on data_in |
| data_in | input | 8*BYTES | Payload word, bit 0 sent first |
| ready | output | 1 | Low marks the last taken word before a pause, and the pause |
| tx_word | output | 8*BYTES | Output line word, bit 0 earliest |

## Verification
A wrong surplus count or a wrong word index inside the block shows on `tx_word` at the next edge. Every later bit is then shifted or lost, so a bit-exact comparison against an independently built stream catches it at once. A pause that is scheduled one block early or late shows on `ready` within one 33-cycle period. It also leaves the output one word short or one word long, so the stream comparison fails within a few words. Faults in the idle, start and reset behaviour show in the cycle after the edge concerned.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;
   localparam int unsigned BLOCK_PAYLOAD = 64;
   localparam int unsigned HOLD_BYTES    = 4;

   typedef struct packed {
      logic take;   // a user word is consumed this cycle
      logic run;    // an output word is produced this cycle
      logic lead;   // the word taken is the first of its block
   } gbx_ctl_t;
endpackage

// File: rtl/gbx_seq.sv
`timescale 1ns/1ps
module gbx_seq
   import gbx_pkg::*;
#(
   parameter int unsigned BYTES  = 4,
   parameter int unsigned HDR_W  = 2,
   parameter int unsigned FILL_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_seq,
   input  logic [FILL_W-1:0] fill_nx,
   output gbx_ctl_t          ctl,
   output logic              ready
);
   localparam int unsigned WORD_W    = 8 * BYTES;
   localparam int unsigned WORDS_BLK = BLOCK_PAYLOAD / WORD_W;
   localparam int unsigned IDX_W     = $clog2(WORDS_BLK);
   localparam int unsigned HOLD_BITS = 8 * HOLD_BYTES;
   localparam int unsigned HOLD_CYC  = HOLD_BITS / WORD_W;
   localparam int unsigned CNT_W     = $clog2(HOLD_CYC + 1);

   logic             ready_q, en_q, started_q;
   logic [IDX_W-1:0] idx_q, idx_nx;
   logic [CNT_W-1:0] hold_q;
   logic             take, run, lead_nx;
   logic [FILL_W:0]  due;

   always_comb begin
      take    = started_q ? en_q : (ready_q & start_seq);
      run     = started_q | take;
      idx_nx  = take ? idx_q + 1'b1 : idx_q;
      lead_nx = (idx_nx == '0);
      due     = {1'b0, fill_nx} + (lead_nx ? (FILL_W+1)'(HDR_W) : '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q   <= 1'b0;
         en_q      <= 1'b0;
         started_q <= 1'b0;
         idx_q     <= '0;
         hold_q    <= '0;
      end else begin
         en_q  <= ready_q;
         idx_q <= idx_nx;
         if (take) started_q <= 1'b1;
         if (hold_q != '0) begin
            hold_q  <= hold_q - 1'b1;
            ready_q <= (hold_q == CNT_W'(1));
         end else if (run && ready_q && due >= (FILL_W+1)'(HOLD_BITS)) begin
            hold_q  <= CNT_W'(HOLD_CYC);
            ready_q <= 1'b0;
         end else begin
            ready_q <= 1'b1;
         end
      end
   end

   assign ctl   = '{take: take, run: run, lead: (idx_q == '0)};
   assign ready = ready_q;

   // R1: the cycle after a reset edge never shows ready high
   assert_ready_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !ready_q);

   // R6: the first low-ready cycle of a running stream still consumes a word
   assert_first_low_takes_R6: assert property (@(posedge clk) disable iff (rst)
      (started_q && $fell(ready_q)) |-> take);

   generate
      if (HOLD_CYC == 1) begin : g_shape_one
         // R7: one idle cycle, ready already back high in it
         assert_pause_shape_R7: assert property (@(posedge clk) disable iff (rst)
            (started_q && $fell(ready_q)) |=> (ready_q && !take));
      end else begin : g_shape_two
         // R7: two idle cycles, ready high only in the second
         assert_pause_shape_R7: assert property (@(posedge clk) disable iff (rst)
            (started_q && $fell(ready_q)) |=> (!ready_q && !take) ##1 (ready_q && !take));
      end
   endgenerate
endmodule

// File: rtl/gbx_pack.sv
`timescale 1ns/1ps
module gbx_pack
   import gbx_pkg::*;
#(
   parameter int unsigned BYTES  = 4,
   parameter int unsigned HDR_W  = 2,
   parameter int unsigned ACC_W  = 68,
   parameter int unsigned FILL_W = 7,
   parameter logic [8*BYTES-1:0] IDLE_WORD = '0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  gbx_ctl_t             ctl,
   input  logic [HDR_W-1:0]     hdr_in,
   input  logic [8*BYTES-1:0]   data_in,
   output logic [FILL_W-1:0]    fill_nx,
   output logic [8*BYTES-1:0]   tx_word
);
   localparam int unsigned WORD_W    = 8 * BYTES;
   localparam int unsigned HOLD_BITS = 8 * HOLD_BYTES;

   logic [ACC_W-1:0]  acc_q, ins, merged;
   logic [FILL_W-1:0] fill_q, push_n;
   logic [WORD_W-1:0] out_q;

   always_comb begin
      ins    = '0;
      push_n = '0;
      if (ctl.take) begin
         if (ctl.lead) begin
            ins    = ACC_W'({data_in, hdr_in});
            push_n = FILL_W'(WORD_W + HDR_W);
         end else begin
            ins    = ACC_W'(data_in);
            push_n = FILL_W'(WORD_W);
         end
      end
      merged  = acc_q | (ins << fill_q);
      fill_nx = ctl.run ? (fill_q + push_n - FILL_W'(WORD_W)) : fill_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         fill_q <= '0;
         out_q  <= IDLE_WORD;
      end else if (ctl.run) begin
         acc_q  <= merged >> WORD_W;
         fill_q <= fill_nx;
         out_q  <= merged[WORD_W-1:0];
      end
   end

   assign tx_word = out_q;

   // R2: no word produced yet means the idle pattern is still on the line
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !ctl.run |-> (tx_word == IDLE_WORD));

   // R8: the scheduler never lets the surplus grow past one pause worth plus a header
   assert_fill_cap_R8: assert property (@(posedge clk) disable iff (rst)
      fill_q < FILL_W'(HOLD_BITS + HDR_W));

   // R9: every produced word finds enough buffered bits
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
      ctl.run |-> (({1'b0, fill_q} + {1'b0, push_n}) >= (FILL_W+1)'(WORD_W)));
endmodule

// File: rtl/gbx_tx.sv
`timescale 1ns/1ps
module gbx_tx
   import gbx_pkg::*;
#(
   parameter int unsigned BYTES = 4,
   parameter int unsigned HDR_W = 2,
   parameter logic [8*BYTES-1:0] IDLE_WORD = {(4*BYTES){2'b01}}
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start_seq,
   input  logic [HDR_W-1:0]     hdr_in,
   input  logic [8*BYTES-1:0]   data_in,
   output logic                 ready,
   output logic [8*BYTES-1:0]   tx_word
);
   localparam int unsigned WORD_W    = 8 * BYTES;
   localparam int unsigned HOLD_BITS = 8 * HOLD_BYTES;
   localparam int unsigned ACC_W     = HOLD_BITS + 2 * HDR_W + WORD_W;
   localparam int unsigned FILL_W    = $clog2(ACC_W + 1);

   generate
      if (BYTES != 2 && BYTES != 4) begin : g_bad_bytes
         $error("gbx_tx: BYTES must be 2 or 4");
      end
      if (HDR_W != 2 && HDR_W != 3) begin : g_bad_hdr
         $error("gbx_tx: HDR_W must be 2 (66-bit blocks) or 3 (67-bit blocks)");
      end
   endgenerate

   gbx_ctl_t          ctl;
   logic [FILL_W-1:0] fill_nx;

   gbx_seq #(
      .BYTES(BYTES), .HDR_W(HDR_W), .FILL_W(FILL_W)
   ) u_seq (
      .clk(clk), .rst(rst), .start_seq(start_seq),
      .fill_nx(fill_nx), .ctl(ctl), .ready(ready)
   );

   gbx_pack #(
      .BYTES(BYTES), .HDR_W(HDR_W), .ACC_W(ACC_W), .FILL_W(FILL_W),
      .IDLE_WORD(IDLE_WORD)
   ) u_pack (
      .clk(clk), .rst(rst), .ctl(ctl), .hdr_in(hdr_in), .data_in(data_in),
      .fill_nx(fill_nx), .tx_word(tx_word)
   );
endmodule

// File: tb/test_gbx_tx.sv
`timescale 1ns/1ps
module test_gbx_tx;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_seq = 1'b0;
   logic [1:0]  hdr_a = '0;
   logic [31:0] dat_a = '0;
   logic        rdy_a;
   logic [31:0] tx_a;
   logic [2:0]  hdr_b = '0;
   logic [15:0] dat_b = '0;
   logic        rdy_b;
   logic [15:0] tx_b;

   always #4 clk = ~clk;   // 8 ns period

   // instance 0: 4-byte words, 2-bit header
   gbx_tx #(.BYTES(4), .HDR_W(2)) i_gbx_tx (
      .clk(clk), .rst(rst), .start_seq(start_seq), .hdr_in(hdr_a),
      .data_in(dat_a), .ready(rdy_a), .tx_word(tx_a));
   // instance 1: 2-byte words, 3-bit header
   gbx_tx #(.BYTES(2), .HDR_W(3)) i_gbx_tx_b (
      .clk(clk), .rst(rst), .start_seq(start_seq), .hdr_in(hdr_b),
      .data_in(dat_b), .ready(rdy_b), .tx_word(tx_b));

   int checks = 0;
   int errors = 0;
   logic [127:0] sb [2];
   int           sb_n [2];
   bit           started_m [2];
   bit           prev_rdy [2];
   int           widx [2];
   logic [31:0]  exp_w [2];
   bit           exp_act [2];
   int           cyc [2];
   int           run_len [2];
   int           pauses [2];

   function automatic int wid(input int i);
      return (i == 0) ? 32 : 16;
   endfunction
   function automatic int hbits(input int i);
      return (i == 0) ? 2 : 3;
   endfunction
   function automatic logic [31:0] idle_of(input int i);
      return (i == 0) ? 32'h5555_5555 : 32'h0000_5555;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         sb[i] = '0; sb_n[i] = 0; started_m[i] = 0; prev_rdy[i] = 0;
         widx[i] = 0; exp_act[i] = 0; cyc[i] = 0; run_len[i] = 0; pauses[i] = 0;
      end
   endtask

   // one cycle of the reference stream for instance i
   task automatic mdl(input int i, input bit st, input logic [31:0] d,
                      input logic [2:0] h, input bit rdy_now);
      bit take;
      int w;
      int hb;
      logic [127:0] wmask;
      w = wid(i);
      hb = hbits(i);
      wmask = (128'd1 << w) - 128'd1;
      take = started_m[i] ? prev_rdy[i] : (rdy_now && st);   // R6/R7 acceptance rule
      if (started_m[i]) begin
         cyc[i]++;
         if (!rdy_now) begin
            if (run_len[i] == 0) begin
               pauses[i]++;
               if (i == 0) chk("R8 pause position (cycle-30) mod 33", 32'((cyc[i] - 30) % 33), 32'd0);
            end
            run_len[i]++;
         end else if (run_len[i] > 0) begin
            chk("R7 ready-low run length", 32'(run_len[i]), 32'(32 / w));
            run_len[i] = 0;
         end
      end
      if (take) begin
         if (widx[i] == 0) begin
            sb[i] = sb[i] | ((128'(h) & ((128'd1 << hb) - 128'd1)) << sb_n[i]);
            sb_n[i] += hb;
         end
         sb[i] = sb[i] | ((128'(d) & wmask) << sb_n[i]);
         sb_n[i] += w;
         widx[i] = (widx[i] + 1) % (64 / w);
      end
      if (started_m[i] || take) begin
         if (sb_n[i] < w) begin
            checks++; errors++;
            $display("FAIL R9 buffer short: actual %0d bits expected at least %0d", sb_n[i], w);
         end
         exp_w[i] = 32'(sb[i] & wmask);
         sb[i] = sb[i] >> w;
         sb_n[i] -= w;
         exp_act[i] = 1;
      end
      if (take && !started_m[i]) begin
         started_m[i] = 1;
         cyc[i] = 0;
         pauses[i] = 0;
      end
      prev_rdy[i] = rdy_now;
   endtask

   task automatic step(input bit st, input bit r, input string tag);
      logic [31:0] da;
      logic [15:0] db;
      logic [1:0]  ha;
      logic [2:0]  hb;
      @(negedge clk);
      chk({tag, " word0"}, tx_a, exp_act[0] ? exp_w[0] : idle_of(0));
      chk({tag, " word1"}, {16'h0, tx_b}, exp_act[1] ? exp_w[1] : idle_of(1));
      da = $urandom; db = 16'($urandom); ha = 2'($urandom); hb = 3'($urandom);
      rst = r; start_seq = st;
      dat_a = da; dat_b = db; hdr_a = ha; hdr_b = hb;
      if (r) model_reset();
      else begin
         mdl(0, st, da, {1'b0, ha}, rdy_a);
         mdl(1, st, {16'h0, db}, hb, rdy_b);
      end
   endtask

   task automatic t_reset();
      step(0, 1, "R1 reset");
      step(0, 1, "R1 reset");
      chk("R1 ready low in reset a", {31'h0, rdy_a}, 32'd0);
      chk("R1 ready low in reset b", {31'h0, rdy_b}, 32'd0);
      step(0, 0, "R1 release");
      chk("R1 ready low before first clean edge", {31'h0, rdy_a}, 32'd0);
      step(0, 0, "R1 release");
      chk("R1 ready high after release a", {31'h0, rdy_a}, 32'd1);
      chk("R1 ready high after release b", {31'h0, rdy_b}, 32'd1);
   endtask

   task automatic t_wait();
      for (int k = 0; k < 20; k++) step(0, 0, "R2 idle wait");
      chk("R2 ready high while waiting", {31'h0, rdy_a}, 32'd1);
   endtask

   task automatic t_start();
      logic [31:0] ea;
      logic [31:0] eb;
      step(1, 0, "R3 start");
      ea = {dat_a[29:0], hdr_a};
      eb = {16'h0, dat_b[12:0], hdr_b};
      step(1, 0, "R3 second");
      chk("R3 first word a", tx_a, ea);
      chk("R3 first word b", {16'h0, tx_b}, eb);
   endtask

   task automatic t_stream();
      // start_seq toggles at random: R10; header randomised on every word: R5
      for (int k = 0; k < 120; k++) step(1'($urandom), 0, "R4 R5 R9 R10 stream");
   endtask

   task automatic t_pause();
      int expn;
      for (int k = 0; k < 400; k++) step(0, 0, "R6 R7 stream across pauses");
      expn = (cyc[0] >= 30) ? ((cyc[0] - 30) / 33 + 1) : 0;
      chk("R8 pause count a", 32'(pauses[0]), 32'(expn));
      chk("R8 pauses seen b", {31'h0, pauses[1] > 10}, 32'd1);
   endtask

   task automatic t_restart();
      step(0, 1, "R11 reset mid-stream");
      step(0, 0, "R11 reset mid-stream");
      chk("R11 ready low after reset", {31'h0, rdy_a}, 32'd0);
      for (int k = 0; k < 10; k++) step(0, 0, "R11 idle after reset");
      for (int k = 0; k < 150; k++) step(1, 0, "R11 restarted stream");
   endtask

   initial begin
      model_reset();
      t_reset();
      t_wait();
      t_start();
      t_stream();
      t_pause();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule